// File: doc/BRIEF.md
# Trace Status and Address Nibble Serializer

This block sits at the edge of a processor core and turns instruction-completion events into a narrow trace stream. Each cycle the core offers at most one event. The event carries a valid flag, a taken-branch flag, a capture flag and a size flag that selects a 16-bit or a 32-bit branch target. In the following cycle the block drives a 4-bit status code for that event. The status code is registered, so it trails the event by exactly one clock.

A captured target is split into a marker nibble followed by its address nibbles, least significant first. These nibbles are placed in a small nibble FIFO, and the FIFO sends one nibble per cycle onto a separate 4-bit data bus. Because of this queue, status codes for later instructions can be issued while an earlier address is still being sent. A capture is accepted only when the whole marker-plus-address sequence fits in the FIFO at once. When it does not fit, the block raises a combinational stall to the core. The core must then hold the event, and the status bus shows the idle code until room is available.

Top module: `trace_nibble_port`

## Requirements
- R1: A synchronous active-high reset empties the FIFO. After the first clock edge with reset high, both the status bus and the data bus read 0x0.
- R2: The status bus shows the code for the event of the previous cycle. It shows 0x0 when no event was valid, and 0x1 for an accepted completion with the taken flag low.
- R3: An accepted completion with the taken flag high shows status 0x5 on the next cycle.
- R4: A 16-bit capture (size flag 0) is queued as five nibbles: marker 0x9, then target bits [3:0], [7:4], [11:8], [15:12].
- R5: A 32-bit capture (size flag 1) is queued as nine nibbles: marker 0xB, then the eight target nibbles from bits [3:0] up to bits [31:28].
- R6: The data bus shows exactly one queued nibble per cycle, in queue order. It shows 0x0 in any cycle that follows a cycle in which the FIFO was empty.
- R7: Stall is high, in the same cycle, exactly when a valid taken capture needs more free entries than the FIFO of 16 nibbles has at the start of that cycle. The FIFO is judged before that cycle's dequeue. A stalled event is not queued, and the next status is 0x0.
- R8: Events without a capture never stall, and their status codes are issued while earlier address nibbles are still draining.
- R9: The capture flag is ignored when the taken flag is low. No nibbles are queued, no stall is raised, and the status is 0x1.
- R10: The taken, capture and size flags are ignored when the valid flag is low. The status is 0x0, nothing is queued and there is no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst | input | 1 | Synchronous reset, active high |
| evtValid | input | 1 | An instruction completed this cycle |
| evtTaken | input | 1 | The completed instruction was a taken branch |
| evtCapture | input | 1 | The branch target should be sent on the data bus |
| evtWide | input | 1 | Target size: 0 = 16 bits, 1 = 32 bits |
| evtTarget | input | 32 | Captured branch target |
| stall | output | 1 | Core must hold its event; the FIFO lacks room |
| statusOut | output | 4 | Registered status code of the previous cycle's event |
| dataOut | output | 4 | Registered nibble drained from the FIFO |

## Verification
The bound checker verifies the following on every cycle:
- the status code that follows idle, plain, taken and stalled events;
- that stall only ever accompanies a valid taken capture;
- that the FIFO occupancy stays within its bound;
- that an empty FIFO yields 0x0 on the data bus;
- that a capture into an empty FIFO leads with the correct marker two cycles later.

Only the bench scenarios can show that every address nibble comes out in the right order and value, and that back-to-back wide captures hold the core for the right number of cycles. The same applies to status codes running ahead of the draining data. For these, the bench keeps its own nibble queue and compares against it.

// File: rtl/trace_port_pkg.sv
package trace_port_pkg;

  localparam logic [3:0] STAT_IDLE  = 4'h0;
  localparam logic [3:0] STAT_PLAIN = 4'h1;
  localparam logic [3:0] STAT_TAKEN = 4'h5;

  localparam logic [3:0] MARK_NARROW = 4'h9;
  localparam logic [3:0] MARK_WIDE   = 4'hB;

  localparam int NARROW_NIBS = 4;
  localparam int WIDE_NIBS   = 8;
  localparam int MAX_SEQ     = WIDE_NIBS + 1;

  typedef struct packed {
    logic push;
    logic wide;
    logic pop;
  } fifo_strobe_t;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_port_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evtValid,
  input  logic             evtTaken,
  input  logic             evtCapture,
  input  logic             evtWide,
  input  logic [CNT_W-1:0] fifoCount,
  output logic             stall,
  output fifo_strobe_t     strb,
  output logic [3:0]       statusOut
);

  localparam int SUM_W = CNT_W + 2;

  logic             wantCapture;
  logic [SUM_W-1:0] seqLen;
  logic [SUM_W-1:0] fillAfter;
  logic             hasRoom;

  // Capture is only honoured for a valid, taken branch.
  assign wantCapture = evtValid & evtTaken & evtCapture;
  assign seqLen      = evtWide ? SUM_W'(WIDE_NIBS + 1) : SUM_W'(NARROW_NIBS + 1);
  assign fillAfter   = SUM_W'(fifoCount) + seqLen;
  assign hasRoom     = (fillAfter <= SUM_W'(DEPTH));

  assign stall     = wantCapture & ~hasRoom;
  assign strb.push = wantCapture & hasRoom;
  assign strb.wide = evtWide;
  assign strb.pop  = (fifoCount != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      statusOut <= STAT_IDLE;
    end else if (!evtValid || stall) begin
      statusOut <= STAT_IDLE;
    end else if (evtTaken) begin
      statusOut <= STAT_TAKEN;
    end else begin
      statusOut <= STAT_PLAIN;
    end
  end

endmodule

// File: rtl/trace_fifo_path.sv
module trace_fifo_path
  import trace_port_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  fifo_strobe_t     strb,
  input  logic [31:0]      evtTarget,
  output logic [CNT_W-1:0] fifoCount,
  output logic [3:0]       dataOut
);

  logic [3:0]       nibMem  [DEPTH];
  logic [3:0]       seqNib  [MAX_SEQ];
  logic [PTR_W-1:0] slotOff [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] pushLen;
  logic [CNT_W-1:0] addCnt;
  logic [CNT_W-1:0] subCnt;

  // Build the marker-first sequence, address nibbles least significant first.
  always_comb begin
    seqNib[0] = strb.wide ? MARK_WIDE : MARK_NARROW;
    for (int n = 1; n < MAX_SEQ; n++) begin
      seqNib[n] = evtTarget[4*(n-1) +: 4];
    end
  end

  assign pushLen = strb.wide ? PTR_W'(WIDE_NIBS + 1) : PTR_W'(NARROW_NIBS + 1);
  assign addCnt  = strb.push ? CNT_W'(pushLen) : '0;
  assign subCnt  = strb.pop ? CNT_W'(1) : '0;

  // Distance of each slot from the write pointer (power-of-two wrap).
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    assign slotOff[s] = PTR_W'(s) - wrPtr;
  end

  function automatic logic [3:0] pickNib(input logic [PTR_W-1:0] idx,
                                         input logic [3:0] seq [MAX_SEQ]);
    logic [3:0] res;
    res = '0;
    for (int k = 0; k < MAX_SEQ; k++) begin
      if (idx == PTR_W'(k)) res = seq[k];
    end
    return res;
  endfunction

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (strb.push && (slotOff[s] < pushLen)) begin
        nibMem[s] <= pickNib(slotOff[s], seqNib);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      fifoCount <= '0;
      dataOut   <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + pushLen;
      if (strb.pop) begin
        rdPtr   <= rdPtr + PTR_W'(1);
        dataOut <= nibMem[rdPtr];
      end else begin
        dataOut <= '0;
      end
      fifoCount <= fifoCount + addCnt - subCnt;
    end
  end

endmodule

// File: rtl/trace_nibble_port.sv
module trace_nibble_port
  import trace_port_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        evtValid,
  input  logic        evtTaken,
  input  logic        evtCapture,
  input  logic        evtWide,
  input  logic [31:0] evtTarget,
  output logic        stall,
  output logic [3:0]  statusOut,
  output logic [3:0]  dataOut
);

  fifo_strobe_t     strb;
  logic [CNT_W-1:0] fifoCount;
  logic             pushStb;
  logic             pushWide;

  assign pushStb  = strb.push;
  assign pushWide = strb.wide;

  trace_ctrl #(.DEPTH(DEPTH)) ctrlInst (
    .clk(clk), .rst(rst),
    .evtValid(evtValid), .evtTaken(evtTaken),
    .evtCapture(evtCapture), .evtWide(evtWide),
    .fifoCount(fifoCount), .stall(stall),
    .strb(strb), .statusOut(statusOut)
  );

  trace_fifo_path #(.DEPTH(DEPTH)) pathInst (
    .clk(clk), .rst(rst), .strb(strb),
    .evtTarget(evtTarget), .fifoCount(fifoCount),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/trace_nibble_port_chk.sv
module trace_nibble_port_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             evtValid,
  input logic             evtTaken,
  input logic             evtCapture,
  input logic             stall,
  input logic [3:0]       statusOut,
  input logic [3:0]       dataOut,
  input logic [CNT_W-1:0] fifoCount,
  input logic             pushStb,
  input logic             pushWide
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (statusOut == 4'h0 && dataOut == 4'h0 && fifoCount == '0));

  assert_idle_status_R2: assert property (@(posedge clk) disable iff (rst)
    !evtValid |=> statusOut == 4'h0);

  assert_plain_status_R2: assert property (@(posedge clk) disable iff (rst)
    (evtValid && !evtTaken) |=> statusOut == 4'h1);

  assert_taken_status_R3: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtTaken && !stall) |=> statusOut == 4'h5);

  assert_narrow_marker_R4: assert property (@(posedge clk) disable iff (rst)
    (pushStb && !pushWide && fifoCount == '0) |=> ##1 dataOut == 4'h9);

  assert_wide_marker_R5: assert property (@(posedge clk) disable iff (rst)
    (pushStb && pushWide && fifoCount == '0) |=> ##1 dataOut == 4'hB);

  assert_empty_data_R6: assert property (@(posedge clk) disable iff (rst)
    (fifoCount == '0) |=> dataOut == 4'h0);

  assert_stall_status_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> statusOut == 4'h0);

  assert_stall_cause_R7: assert property (@(posedge clk) disable iff (rst)
    stall |-> (evtValid && evtTaken && evtCapture && !pushStb));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    fifoCount <= CNT_W'(DEPTH));

endmodule

bind trace_nibble_port trace_nibble_port_chk #(.DEPTH(DEPTH)) chkInst (
  .clk(clk), .rst(rst), .evtValid(evtValid), .evtTaken(evtTaken),
  .evtCapture(evtCapture), .stall(stall), .statusOut(statusOut),
  .dataOut(dataOut), .fifoCount(fifoCount), .pushStb(pushStb),
  .pushWide(pushWide)
);

// File: tb/trace_nibble_port_test.sv
module trace_nibble_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int FIFO_DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evtValid = 1'b0;
  logic        evtTaken = 1'b0;
  logic        evtCapture = 1'b0;
  logic        evtWide = 1'b0;
  logic [31:0] evtTarget = '0;
  logic        stall;
  logic [3:0]  statusOut;
  logic [3:0]  dataOut;

  int checks = 0;
  int failures = 0;
  int modelQ[$];
  bit finished = 1'b0;

  trace_nibble_port uut (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtTaken(evtTaken),
    .evtCapture(evtCapture), .evtWide(evtWide), .evtTarget(evtTarget),
    .stall(stall), .statusOut(statusOut), .dataOut(dataOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One event cycle; returns whether the core's event was accepted.
  task automatic step(input bit v, input bit t, input bit c, input bit w,
                      input logic [31:0] tgt, input string tag, output bit accepted);
    bit expStall, want;
    int need, expStatus, expData;
    @(negedge clk);
    evtValid = v; evtTaken = t; evtCapture = c; evtWide = w; evtTarget = tgt;
    #1;
    want = v && t && c;
    need = w ? 9 : 5;
    expStall = want && (modelQ.size() + need > FIFO_DEPTH);
    chk(stall == expStall, expStall ? "R7" : (v ? (t ? "R8" : "R9") : "R10"),
        int'(stall), int'(expStall));
    expStatus = (!v || expStall) ? 0 : (t ? 5 : 1);
    if (modelQ.size() > 0) expData = modelQ.pop_front();
    else expData = 0;
    if (want && !expStall) begin
      modelQ.push_back(w ? 'hB : 'h9);
      for (int k = 0; k < need - 1; k++) modelQ.push_back(int'((tgt >> (4 * k)) & 32'hF));
    end
    accepted = !expStall;
    @(posedge clk);
    #1;
    chk(statusOut == 4'(expStatus), expStall ? "R7" : (!v ? "R2" : (t ? "R3" : "R2")),
        int'(statusOut), expStatus);
    chk(dataOut == 4'(expData), (expData == 0) ? "R6" : tag, int'(dataOut), expData);
  endtask

  task automatic issue(input bit v, input bit t, input bit c, input bit w,
                       input logic [31:0] tgt, input string tag);
    bit acc;
    for (int tries = 0; tries < 20; tries++) begin
      step(v, t, c, w, tgt, tag, acc);
      if (acc) break;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] lfsr;
    bit acc;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(statusOut == 4'h0, "R1", int'(statusOut), 0);
    chk(dataOut == 4'h0, "R1", int'(dataOut), 0);
    chk(stall == 1'b0, "R1", int'(stall), 0);

    // R4: 16-bit capture, nibble order checked explicitly too
    step(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000BEEF, "R4", acc);
    idle(6, "R4");
    // R5: 32-bit capture
    issue(1'b1, 1'b1, 1'b1, 1'b1, 32'h1234_5678, "R5");
    idle(10, "R5");
    // R8: plain and taken-without-capture events while data drains
    issue(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000A5C3, "R8");
    issue(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R8");
    issue(1'b1, 1'b1, 1'b0, 1'b1, 32'h0, "R8");
    issue(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R8");
    idle(4, "R6");
    // R9: capture ignored without taken; R10: flags ignored without valid
    issue(1'b1, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R9");
    issue(1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, "R10");
    idle(2, "R6");
    // R7: back-to-back wide captures force stalls
    issue(1'b1, 1'b1, 1'b1, 1'b1, 32'hCAFE_F00D, "R7");
    issue(1'b1, 1'b1, 1'b1, 1'b1, 32'h8765_4321, "R7");
    issue(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_9ABC, "R7");
    issue(1'b1, 1'b1, 1'b1, 1'b1, 32'h0F1E_2D3C, "R7");
    idle(20, "R6");
    // Near-exhaustive sweep over all flag patterns with varied targets
    lfsr = 32'h1ACE_B00C;
    for (int rep = 0; rep < 40; rep++) begin
      for (int pat = 0; pat < 16; pat++) begin
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        issue(pat[0], pat[1], pat[2], pat[3], lfsr, "R8");
      end
    end
    idle(20, "R6");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule